// File: doc/BRIEF.md
# Flag-Driven Branch and Program Counter Unit

This unit produces the program counter of a processor that retires one instruction per clock. Decoded operation strobes come from the instruction decoder. A compare strobe records whether two source operands differ, and that record stays in a one-bit flag register until the next compare. The two conditional branch strobes test the recorded flag. Each branch redirects to a full program-counter value that it reads from a 32-entry target table, using a 5-bit branch index. The naming of the two branches is deliberately inverted. The branch strobe called "beq" is taken when the recorded operands were unequal. The one called "bne" is taken when they were equal.

A jump strobe loads a 6-bit absolute target, zero-extended to the PC width. When there is no jump and no taken branch, the PC steps by one. The target table is filled through a write port, and that port is honoured only while reset is asserted. When the PC reaches a configurable end address, the unit raises `done` and the PC freezes.

Top module: `branch_pc_unit`

## Requirements
- R1: While `rst_n` is low the PC is 0 and the compare flag is cleared to the "equal" state, so a `bne` strobe issued in the first cycle after reset is taken.
- R2: A cycle with `op_cmp` high records whether `src_a` and `src_b` differ. The record considers all bits of the operands. It remains unchanged through cycles without `op_cmp`.
- R3: When `op_beq` is high and the recorded flag says the operands differed, the PC at the next clock edge is the table entry selected by `br_idx`.
- R4: When `op_bne` is high and the recorded flag says the operands were equal, the PC at the next clock edge is the table entry selected by `br_idx`.
- R5: A branch strobe whose condition is not met does not redirect, and the PC advances by one.
- R6: A cycle with `op_jmp` high loads `jmp_tgt`, zero-extended, into the PC at the next edge. A jump takes priority over any branch strobe in the same cycle.
- R7: With no jump and no taken branch, the PC increases by exactly one per clock.
- R8: A table write (`tbl_we`) takes effect only while `rst_n` is low. A write with `rst_n` high leaves the entry unchanged.
- R9: `done` is high exactly when the PC equals `END_ADDR`. From then on the PC holds its value and ignores jumps and branches.
- R10: A branch uses the flag recorded before its own cycle. A compare issued in the same cycle as a branch affects only later branches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; also opens the table write port |
| op_cmp | input | 1 | Compare-subtract strobe |
| op_beq | input | 1 | Branch taken when the recorded operands differed |
| op_bne | input | 1 | Branch taken when the recorded operands were equal |
| op_jmp | input | 1 | Absolute jump strobe |
| src_a | input | DATA_W (8) | First compare operand |
| src_b | input | DATA_W (8) | Second compare operand |
| br_idx | input | IDX_W (5) | Index into the branch target table |
| jmp_tgt | input | JMP_W (6) | Absolute jump target |
| tbl_we | input | 1 | Target table write enable |
| tbl_waddr | input | IDX_W (5) | Target table write index |
| tbl_wdata | input | PC_W (8) | Target table write value |
| pc | output | PC_W (8) | Current program counter |
| done | output | 1 | PC has reached END_ADDR |

## Verification
Every PC result is due at the first clock edge after the cycle in which its strobes were driven. A compare affects only the branches issued one or more cycles later. `done` follows the PC in the same cycle with no extra delay. The driver applies each instruction's strobes just after a falling edge. It computes the expected PC and `done` from a model of the requirements and queues them. The monitor pops one entry a short time after each rising edge, so each comparison falls in the cycle when the result becomes valid. For R8, the bench writes a table entry during run mode and then branches through that index. This makes the unchanged entry visible on `pc`.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
   typedef enum logic [1:0] {
      PC_STEP   = 2'd0,
      PC_BRANCH = 2'd1,
      PC_JUMP   = 2'd2,
      PC_HOLD   = 2'd3
   } pc_sel_e;
endpackage

// File: rtl/bpu_cmp_flag.sv
module bpu_cmp_flag #(
   parameter int DATA_W  = 8,
   parameter bit USE_SUB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_en,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   output logic              differ_q
);
   logic differ_d;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("bpu_cmp_flag: DATA_W must be positive");
      end
      if (USE_SUB) begin : g_sub
         logic [DATA_W-1:0] diff;
         always_comb begin
            diff     = opnd_a - opnd_b;
            differ_d = |diff;
         end
      end else begin : g_xor
         always_comb differ_d = |(opnd_a ^ opnd_b);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      differ_q <= 1'b0;
      else if (cmp_en) differ_q <= differ_d;
   end

   // R2: the recorded outcome survives cycles without a compare
   a_r2_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_en |=> $stable(differ_q));
   // R2: a compare of unequal operands records "differ"
   a_r2_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_en && (opnd_a != opnd_b) |=> differ_q);
endmodule

// File: rtl/bpu_target_lut.sv
module bpu_target_lut #(
   parameter int IDX_W = 5,
   parameter int PC_W  = 8
) (
   input  logic             clk,
   input  logic             wr_open,
   input  logic             we,
   input  logic [IDX_W-1:0] waddr,
   input  logic [PC_W-1:0]  wdata,
   input  logic [IDX_W-1:0] raddr,
   output logic [PC_W-1:0]  rdata
);
   localparam int DEPTH = 1 << IDX_W;

   generate
      if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
         $error("bpu_target_lut: IDX_W out of range");
      end
   endgenerate

   logic [PC_W-1:0] entry [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_open && we) entry[waddr] <= wdata;
   end

   assign rdata = entry[raddr];

   // R8: a write outside the reset window changes nothing
   a_r8_locked_table: assert property (@(posedge clk)
      !wr_open && we |=> entry[$past(waddr)] == $past(entry[waddr]));
endmodule

// File: rtl/bpu_pc_seq.sv
module bpu_pc_seq
   import bpu_pkg::*;
#(
   parameter int PC_W     = 8,
   parameter int JMP_W    = 6,
   parameter int END_ADDR = 60
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             jump,
   input  logic             br_taken,
   input  logic [JMP_W-1:0] jmp_tgt,
   input  logic [PC_W-1:0]  br_tgt,
   output logic [PC_W-1:0]  pc,
   output logic             done
);
   localparam logic [PC_W-1:0] END_PC = PC_W'(END_ADDR);

   generate
      if (JMP_W > PC_W) begin : g_bad_jmp
         $error("bpu_pc_seq: JMP_W wider than PC_W");
      end
      if (END_ADDR < 0 || END_ADDR >= (1 << PC_W)) begin : g_bad_end
         $error("bpu_pc_seq: END_ADDR outside PC range");
      end
   endgenerate

   pc_sel_e         sel;
   logic [PC_W-1:0] pc_next;

   assign done = (pc == END_PC);

   always_comb begin
      if (done)          sel = PC_HOLD;
      else if (jump)     sel = PC_JUMP;
      else if (br_taken) sel = PC_BRANCH;
      else               sel = PC_STEP;
   end

   always_comb begin
      unique case (sel)
         PC_HOLD:   pc_next = pc;
         PC_JUMP:   pc_next = PC_W'(jmp_tgt);
         PC_BRANCH: pc_next = br_tgt;
         default:   pc_next = pc + 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pc <= '0;
      else        pc <= pc_next;
   end

   // R6: jump target lands one edge later
   a_r6_jump_load: assert property (@(posedge clk) disable iff (!rst_n)
      jump && !done |=> pc == PC_W'($past(jmp_tgt)));
   // R7: sequential step
   a_r7_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      !jump && !br_taken && !done |=> pc == $past(pc) + 1'b1);
   // R9: frozen once finished
   a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> $stable(pc) && done);
endmodule

// File: rtl/branch_pc_unit.sv
module branch_pc_unit #(
   parameter int PC_W     = 8,
   parameter int DATA_W   = 8,
   parameter int IDX_W    = 5,
   parameter int JMP_W    = 6,
   parameter int END_ADDR = 60,
   parameter bit USE_SUB  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_cmp,
   input  logic              op_beq,
   input  logic              op_bne,
   input  logic              op_jmp,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [IDX_W-1:0]  br_idx,
   input  logic [JMP_W-1:0]  jmp_tgt,
   input  logic              tbl_we,
   input  logic [IDX_W-1:0]  tbl_waddr,
   input  logic [PC_W-1:0]   tbl_wdata,
   output logic [PC_W-1:0]   pc,
   output logic              done
);
   logic            differ_q;
   logic            br_taken;
   logic [PC_W-1:0] br_tgt;

   bpu_cmp_flag #(.DATA_W(DATA_W), .USE_SUB(USE_SUB)) u_flag (
      .clk(clk), .rst_n(rst_n), .cmp_en(op_cmp),
      .opnd_a(src_a), .opnd_b(src_b), .differ_q(differ_q)
   );

   bpu_target_lut #(.IDX_W(IDX_W), .PC_W(PC_W)) u_lut (
      .clk(clk), .wr_open(!rst_n), .we(tbl_we), .waddr(tbl_waddr),
      .wdata(tbl_wdata), .raddr(br_idx), .rdata(br_tgt)
   );

   // inverted polarity: "beq" fires on a difference, "bne" on equality
   assign br_taken = (op_beq && differ_q) || (op_bne && !differ_q);

   bpu_pc_seq #(.PC_W(PC_W), .JMP_W(JMP_W), .END_ADDR(END_ADDR)) u_seq (
      .clk(clk), .rst_n(rst_n), .jump(op_jmp), .br_taken(br_taken),
      .jmp_tgt(jmp_tgt), .br_tgt(br_tgt), .pc(pc), .done(done)
   );

   // R3: differing operands redirect a beq through the table
   a_r3_beq_taken: assert property (@(posedge clk) disable iff (!rst_n)
      op_beq && differ_q && !op_jmp && !done |=> pc == $past(br_tgt));
   // R4: equal operands redirect a bne through the table
   a_r4_bne_taken: assert property (@(posedge clk) disable iff (!rst_n)
      op_bne && !differ_q && !op_jmp && !done |=> pc == $past(br_tgt));
   // R5: an unmet condition only steps
   a_r5_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
      op_beq && !op_bne && !differ_q && !op_jmp && !done |=> pc == $past(pc) + 1'b1);
endmodule

// File: tb/branch_pc_unit_tb.sv
module branch_pc_unit_tb;
   localparam int END_PC = 60;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_cmp = 0, op_beq = 0, op_bne = 0, op_jmp = 0;
   logic [7:0] src_a = 0, src_b = 0;
   logic [4:0] br_idx = 0;
   logic [5:0] jmp_tgt = 0;
   logic       tbl_we = 0;
   logic [4:0] tbl_waddr = 0;
   logic [7:0] tbl_wdata = 0;
   logic [7:0] pc;
   logic       done;

   int checks = 0, failures = 0;
   int exp_pc[$];
   string exp_tag[$];

   logic [7:0] m_lut [32];
   logic [7:0] m_pc = 0;
   bit         m_differ = 0;

   always #5 clk = ~clk;

   branch_pc_unit u_dut (
      .clk(clk), .rst_n(rst_n), .op_cmp(op_cmp), .op_beq(op_beq), .op_bne(op_bne),
      .op_jmp(op_jmp), .src_a(src_a), .src_b(src_b), .br_idx(br_idx), .jmp_tgt(jmp_tgt),
      .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata), .pc(pc), .done(done)
   );

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // driver: apply one instruction, advance the model, queue the expected PC
   task automatic step(string tag, bit c, bit bq, bit bn, bit j,
                       int a, int b, int idx, int tgt,
                       bit we = 0, int wa = 0, int wd = 0);
      @(negedge clk);
      op_cmp = c; op_beq = bq; op_bne = bn; op_jmp = j;
      src_a = 8'(a); src_b = 8'(b); br_idx = 5'(idx); jmp_tgt = 6'(tgt);
      tbl_we = we; tbl_waddr = 5'(wa); tbl_wdata = 8'(wd);
      if (m_pc == 8'(END_PC))                m_pc = m_pc;
      else if (j)                            m_pc = 8'(tgt);
      else if ((bq && m_differ) || (bn && !m_differ)) m_pc = m_lut[idx];
      else                                   m_pc = m_pc + 8'd1;
      if (c) m_differ = (8'(a) != 8'(b));
      exp_pc.push_back(int'(m_pc));
      exp_tag.push_back(tag);
   endtask

   // monitor: results are due one edge after their strobes
   always @(posedge clk) begin
      #2;
      if (exp_pc.size() > 0) begin
         int e;
         string t;
         e = exp_pc.pop_front();
         t = exp_tag.pop_front();
         check(t, int'(pc), e);
         check({t, "_done"}, int'(done), int'(e == END_PC));
      end
   end

   initial begin
      #(200000 * 10);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < 32; i++) begin
         @(negedge clk);
         m_lut[i] = 8'(i * 7 + 3);
         tbl_we = 1; tbl_waddr = 5'(i); tbl_wdata = m_lut[i];
      end
      @(negedge clk);
      tbl_we = 0;
      check("R1_reset_pc", int'(pc), 0);
      check("R1_reset_done", int'(done), 0);
      @(negedge clk);
      rst_n = 1'b1;
      step("R1_bne_after_reset", 0, 0, 1, 0, 0, 0, 1, 0);   // cleared flag: equal -> 10
      step("R7_step", 0, 0, 0, 0, 0, 0, 0, 0);
      step("R2_cmp_equal", 1, 0, 0, 0, 5, 5, 0, 0);
      step("R5_beq_not_taken", 0, 1, 0, 0, 0, 0, 2, 0);
      step("R4_bne_taken", 0, 0, 1, 0, 0, 0, 2, 0);
      step("R2_cmp_differ", 1, 0, 0, 0, 9, 4, 0, 0);
      step("R7_step2", 0, 0, 0, 0, 0, 0, 0, 0);
      step("R3_beq_taken_held_flag", 0, 1, 0, 0, 0, 0, 3, 0);
      step("R5_bne_not_taken", 0, 0, 1, 0, 0, 0, 3, 0);
      step("R10_cmp_with_beq", 1, 1, 0, 0, 7, 7, 5, 0);       // old flag differ -> taken
      step("R10_bne_new_flag", 0, 0, 1, 0, 0, 0, 0, 0);
      step("R6_jump_over_branch", 0, 0, 1, 1, 0, 0, 1, 40);
      step("R8_run_write", 0, 0, 0, 0, 0, 0, 0, 0, 1, 4, 170);
      step("R8_entry_unchanged", 0, 0, 1, 0, 0, 0, 4, 0);
      step("R2_high_bit_cmp", 1, 0, 0, 0, 128, 0, 0, 0);
      step("R3_beq_high_bit", 0, 1, 0, 0, 0, 0, 6, 0);
      step("R6_jump_max", 0, 0, 0, 1, 0, 0, 0, 63);
      step("R6_jump_near_end", 0, 0, 0, 1, 0, 0, 0, 57);
      step("R7_to_58", 0, 0, 0, 0, 0, 0, 0, 0);
      step("R7_to_59", 0, 0, 0, 0, 0, 0, 0, 0);
      step("R9_reach_end", 0, 0, 0, 0, 0, 0, 0, 0);
      step("R9_hold_jump", 0, 0, 0, 1, 0, 0, 0, 5);
      step("R9_hold_branch", 0, 1, 1, 0, 0, 0, 2, 0);
      step("R9_hold_idle", 0, 0, 0, 0, 0, 0, 0, 0);
      @(negedge clk);
      op_jmp = 0; op_beq = 0; op_bne = 0; op_cmp = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1_reset_again", int'(pc), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule